// File: doc/BRIEF.md
# Flash Interrupt and Status Register Unit

This unit keeps the three host-visible state words of a flash controller: the interrupt word, the controller status word and the system configuration word. A command engine reports each finished operation as a one-cycle event. The event carries a kind (reset, erase, program or load) and an error flag. The unit folds these events into the interrupt and status words. It drives an interrupt pin whose polarity the configuration word selects, and a ready pin.

The host reaches the unit through a small register port with four slots. Slot 0 is configuration, slot 1 is status (read only), slot 2 is interrupts and slot 3 is command. Writes to the interrupt slot can only clear bits. A command write is taken only while the master pending bit is low. A recognised command is handed to the engine as a one-cycle start pulse. An unrecognised command raises an error at once. A host interrupt clear that drops the pending bit also wipes the error flags, which ties acknowledgement to error recovery.

Top module: `flash_irq_status_unit`

## Requirements
- R1: After the asynchronous (cold) reset, the interrupt word reads 0x8080, status reads 0x0000, configuration reads 0x40C0, the command slot reads 0x0000, and rdy_o is 1.
- R2: A one-cycle warm_rst loads the interrupt word with 0x8010, clears status and the command slot, reloads configuration with 0x40C0 and raises rdy_o. It takes priority over any host write or event in the same cycle.
- R3: irq_o equals interrupt bit 15 XOR the inverse of configuration bit 6. It follows either word in the same cycle that word changes.
- R4: A host write to slot 2 replaces the interrupt word with its bitwise AND with the written value.
- R5: When interrupt bit 15 is 0 after such a write, status bits 13..10 are cleared. When bit 15 stays 1, they keep their values.
- R6: An event sets interrupt bit 15 and the bit for its kind: evt_type 0 sets bit 4, 1 sets bit 5, 2 sets bit 6 and 3 sets bit 7.
- R7: An event with evt_err high sets status bit 10. For kinds 1, 2 and 3 it also sets status bit 11, 12 or 13 respectively.
- R8: A command write while interrupt bit 15 is 1 is ignored. No start pulse is issued and the command slot keeps its value.
- R9: An accepted command whose upper byte is zero and whose lower byte is one of 0x00, 0x13, 0x80, 0x1A, 0x1B, 0x23, 0x27, 0x2A, 0x2C, 0x71, 0x94, 0x95, 0xB0, 0x30, 0xF0, 0xF3, 0x65 is stored in the command slot. It produces a one-cycle cmd_start, with cmd_code holding the value, in the cycle after the write.
- R10: An accepted command outside that set is stored, issues no cmd_start, and sets status bit 10 and interrupt bit 15.
- R11: A write to slot 0 stores the configuration and sets rdy_o to bit 7 of the written value. Reads of slot 0 return the stored value with bits 4..0 forced to 0.
- R12: A read returns its data on host_rdata in the cycle after the request, and host_rdata holds that value until the next read. Writes to slot 1 change nothing.
- R13: When a host interrupt write and an event fall in the same cycle, the clear (and any error wipe it causes) is applied first and the event's bits are then added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| warm_rst | input | 1 | Synchronous one-cycle warm reset request |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe |
| host_addr | input | 2 | Register slot: 0 config, 1 status, 2 interrupt, 3 command |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered read data |
| evt_valid | input | 1 | Completion event strobe from the command engine |
| evt_type | input | 2 | Event kind: 0 reset, 1 erase, 2 program, 3 load |
| evt_err | input | 1 | Event finished with an error |
| cmd_start | output | 1 | One-cycle start pulse for an accepted recognised command |
| cmd_code | output | 16 | Currently stored command value |
| irq_o | output | 1 | Interrupt pin, polarity from configuration bit 6 |
| rdy_o | output | 1 | Ready pin |

## Verification
A wrong interrupt word appears on irq_o in the same cycle. It is also visible through the next slot-2 read one cycle later. The most harmful symptom is a stuck pending bit: every later command is rejected, and no cmd_start ever follows a command write. A status word that fails to be wiped shows on the following slot-1 read after the acknowledging write. The bench checks each of these against values worked out from the bit rules, including the case where a clear and an event arrive together.

// File: rtl/fisu_pkg.sv
package fisu_pkg;
  localparam int REG_W = 16;
  localparam int SEL_W = 2;
  localparam int KIND_W = 2;
  localparam int PEND_BIT = 15;
  localparam int KIND_BASE = 4;
  localparam int ERR_CMD_BIT = 10;

  localparam logic [REG_W-1:0] COLD_INT = 16'h8080;
  localparam logic [REG_W-1:0] WARM_INT = 16'h8010;
  localparam logic [REG_W-1:0] CFG_INIT = 16'h40C0;
  localparam logic [REG_W-1:0] ERR_MASK = 16'h3C00;
  localparam logic [REG_W-1:0] CFG_RD_MASK = 16'hFFE0;

  typedef enum logic [KIND_W-1:0] {
    EV_RESET = 2'd0,
    EV_ERASE = 2'd1,
    EV_PROG  = 2'd2,
    EV_LOAD  = 2'd3
  } evt_kind_e;

  typedef enum logic [SEL_W-1:0] {
    SLOT_CFG  = 2'd0,
    SLOT_STAT = 2'd1,
    SLOT_INT  = 2'd2,
    SLOT_CMD  = 2'd3
  } slot_e;

  // interrupt bits raised by a completion event of a given kind
  function automatic logic [REG_W-1:0] evt_int_bits(input evt_kind_e kind);
    logic [REG_W-1:0] v;
    v = '0;
    v[PEND_BIT] = 1'b1;
    v[KIND_BASE + int'(kind)] = 1'b1;
    return v;
  endfunction

  // status bits raised by a failed completion event
  function automatic logic [REG_W-1:0] evt_err_bits(input evt_kind_e kind, input logic err);
    logic [REG_W-1:0] v;
    v = '0;
    if (err) begin
      v[ERR_CMD_BIT] = 1'b1;
      if (kind != EV_RESET) v[ERR_CMD_BIT + int'(kind)] = 1'b1;
    end
    return v;
  endfunction

  function automatic logic cmd_known(input logic [REG_W-1:0] code);
    logic hit;
    case (code[7:0])
      8'h00, 8'h13, 8'h80, 8'h1A, 8'h1B, 8'h23, 8'h27, 8'h2A, 8'h2C,
      8'h71, 8'h94, 8'h95, 8'hB0, 8'h30, 8'hF0, 8'hF3, 8'h65: hit = 1'b1;
      default: hit = 1'b0;
    endcase
    return hit && (code[REG_W-1:8] == '0);
  endfunction

  function automatic logic irq_level(input logic pend, input logic pol);
    return pend ^ ~pol;
  endfunction
endpackage

// File: rtl/fisu_cmd_gate.sv
module fisu_cmd_gate
  import fisu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             warm_rst,
  input  logic             wr_cmd,
  input  logic [REG_W-1:0] wdata,
  input  logic             pending,
  output logic             unknown_cmd,
  output logic             start_q,
  output logic [REG_W-1:0] cmd_q
);
  logic accept;
  logic known;

  assign accept      = wr_cmd && !pending && !warm_rst;
  assign known       = cmd_known(wdata);
  assign unknown_cmd = accept && !known;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      start_q <= 1'b0;
    end else if (warm_rst) begin
      cmd_q   <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= accept && known;
      if (accept) cmd_q <= wdata;
    end
  end
endmodule

// File: rtl/fisu_int_status.sv
module fisu_int_status
  import fisu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_rst,
  input  logic              int_wr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              evt_valid,
  input  logic [KIND_W-1:0] evt_type,
  input  logic              evt_err,
  input  logic              unknown_cmd,
  output logic [REG_W-1:0]  int_q,
  output logic [REG_W-1:0]  stat_q
);
  logic [REG_W-1:0] int_cleared, stat_cleared, int_n, stat_n;
  logic [REG_W-1:0] unk_int, unk_stat;
  evt_kind_e kind;

  assign kind = evt_kind_e'(evt_type);

  always_comb begin
    unk_int  = '0;
    unk_stat = '0;
    unk_int[PEND_BIT]     = unknown_cmd;
    unk_stat[ERR_CMD_BIT] = unknown_cmd;

    int_cleared  = int_wr ? (int_q & wdata) : int_q;
    stat_cleared = (int_wr && !int_cleared[PEND_BIT]) ? (stat_q & ~ERR_MASK) : stat_q;

    int_n  = int_cleared | unk_int;
    stat_n = stat_cleared | unk_stat;
    if (evt_valid) begin
      int_n  = int_n | evt_int_bits(kind);
      stat_n = stat_n | evt_err_bits(kind, evt_err);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q  <= COLD_INT;
      stat_q <= '0;
    end else if (warm_rst) begin
      int_q  <= WARM_INT;
      stat_q <= '0;
    end else begin
      int_q  <= int_n;
      stat_q <= stat_n;
    end
  end
endmodule

// File: rtl/fisu_cfg_reg.sv
module fisu_cfg_reg
  import fisu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             warm_rst,
  input  logic             cfg_wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] cfg_q,
  output logic             rdy_q
);
  localparam int RDY_BIT = 7;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_INIT;
      rdy_q <= 1'b1;
    end else if (warm_rst) begin
      cfg_q <= CFG_INIT;
      rdy_q <= 1'b1;
    end else if (cfg_wr) begin
      cfg_q <= wdata;
      rdy_q <= wdata[RDY_BIT];
    end
  end
endmodule

// File: rtl/fisu_read_port.sv
module fisu_read_port
  import fisu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [SEL_W-1:0] rd_sel,
  input  logic [REG_W-1:0] cfg_q,
  input  logic [REG_W-1:0] stat_q,
  input  logic [REG_W-1:0] int_q,
  input  logic [REG_W-1:0] cmd_q,
  output logic [REG_W-1:0] rdata_q
);
  logic [REG_W-1:0] view;

  always_comb begin
    unique case (slot_e'(rd_sel))
      SLOT_CFG:  view = cfg_q & CFG_RD_MASK;
      SLOT_STAT: view = stat_q;
      SLOT_INT:  view = int_q;
      SLOT_CMD:  view = cmd_q;
      default:   view = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= view;
  end
endmodule

// File: rtl/flash_irq_status_unit.sv
module flash_irq_status_unit
  import fisu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_rst,
  input  logic              host_wr_en,
  input  logic              host_rd_en,
  input  logic [SEL_W-1:0]  host_addr,
  input  logic [REG_W-1:0]  host_wdata,
  output logic [REG_W-1:0]  host_rdata,
  input  logic              evt_valid,
  input  logic [KIND_W-1:0] evt_type,
  input  logic              evt_err,
  output logic              cmd_start,
  output logic [REG_W-1:0]  cmd_code,
  output logic              irq_o,
  output logic              rdy_o
);
  slot_e            sel;
  logic             wr_cfg, wr_int, wr_cmd;
  logic             unknown_w;
  logic             pend_w;
  logic [REG_W-1:0] int_w, stat_w, cfg_w, cmd_w;

  assign sel    = slot_e'(host_addr);
  assign wr_cfg = host_wr_en && (sel == SLOT_CFG);
  assign wr_int = host_wr_en && (sel == SLOT_INT);
  assign wr_cmd = host_wr_en && (sel == SLOT_CMD);
  assign pend_w = int_w[PEND_BIT];

  fisu_cmd_gate u_gate (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
    .wr_cmd(wr_cmd), .wdata(host_wdata), .pending(pend_w),
    .unknown_cmd(unknown_w), .start_q(cmd_start), .cmd_q(cmd_w)
  );

  fisu_int_status u_ist (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
    .int_wr(wr_int), .wdata(host_wdata),
    .evt_valid(evt_valid), .evt_type(evt_type), .evt_err(evt_err),
    .unknown_cmd(unknown_w), .int_q(int_w), .stat_q(stat_w)
  );

  fisu_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
    .cfg_wr(wr_cfg), .wdata(host_wdata), .cfg_q(cfg_w), .rdy_q(rdy_o)
  );

  fisu_read_port u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(host_rd_en), .rd_sel(host_addr),
    .cfg_q(cfg_w), .stat_q(stat_w), .int_q(int_w), .cmd_q(cmd_w),
    .rdata_q(host_rdata)
  );

  assign cmd_code = cmd_w;
  assign irq_o    = irq_level(pend_w, cfg_w[6]);
endmodule

// File: rtl/fisu_checker.sv
module fisu_checker
  import fisu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              warm_rst,
  input logic              host_wr_en,
  input logic              host_rd_en,
  input logic [SEL_W-1:0]  host_addr,
  input logic [REG_W-1:0]  host_wdata,
  input logic [REG_W-1:0]  host_rdata,
  input logic              evt_valid,
  input logic [KIND_W-1:0] evt_type,
  input logic              evt_err,
  input logic              cmd_start,
  input logic              rdy_o,
  input logic [REG_W-1:0]  int_q,
  input logic [REG_W-1:0]  stat_q
);
  assert_warm_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst |=> (int_q == WARM_INT) && (stat_q == '0) && rdy_o);

  assert_err_wipe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_en && host_addr == SLOT_INT && !warm_rst && !evt_valid
     && !((int_q & host_wdata) >> PEND_BIT))
    |=> (stat_q & ERR_MASK) == '0);

  assert_evt_marks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !warm_rst)
    |=> int_q[PEND_BIT] && int_q[KIND_BASE + int'($past(evt_type))]);

  assert_evt_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_err && !warm_rst) |=> stat_q[ERR_CMD_BIT]);

  assert_cmd_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_en && host_addr == SLOT_CMD && int_q[PEND_BIT]) |=> !cmd_start);

  assert_rdy_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_en && host_addr == SLOT_CFG && !warm_rst) |=> rdy_o == $past(host_wdata[7]));

  assert_rd_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_en && host_addr == SLOT_INT) |=> host_rdata == $past(int_q));
endmodule

bind flash_irq_status_unit fisu_checker u_chk (
  .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
  .host_wr_en(host_wr_en), .host_rd_en(host_rd_en), .host_addr(host_addr),
  .host_wdata(host_wdata), .host_rdata(host_rdata),
  .evt_valid(evt_valid), .evt_type(evt_type), .evt_err(evt_err),
  .cmd_start(cmd_start), .rdy_o(rdy_o), .int_q(int_w), .stat_q(stat_w)
);

// File: tb/flash_irq_status_unit_tb.sv
module flash_irq_status_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        warm_rst = 1'b0;
  logic        host_wr_en = 1'b0;
  logic        host_rd_en = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [15:0] host_wdata = 16'h0;
  logic [15:0] host_rdata;
  logic        evt_valid = 1'b0;
  logic [1:0]  evt_type = 2'd0;
  logic        evt_err = 1'b0;
  logic        cmd_start;
  logic [15:0] cmd_code;
  logic        irq_o;
  logic        rdy_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [15:0] v;

  localparam logic [1:0] A_CFG = 2'd0, A_STAT = 2'd1, A_INT = 2'd2, A_CMD = 2'd3;

  always #10 clk = ~clk;

  flash_irq_status_unit u_dut (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
    .host_wr_en(host_wr_en), .host_rd_en(host_rd_en), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .evt_valid(evt_valid), .evt_type(evt_type), .evt_err(evt_err),
    .cmd_start(cmd_start), .cmd_code(cmd_code), .irq_o(irq_o), .rdy_o(rdy_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    host_rd_en = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd_en = 1'b0;
    d = host_rdata;
  endtask

  task automatic evt(input logic [1:0] k, input logic e);
    @(negedge clk);
    evt_valid = 1'b1; evt_type = k; evt_err = e;
    @(negedge clk);
    evt_valid = 1'b0; evt_err = 1'b0;
  endtask

  task automatic t_cold_reset;
    rd(A_INT, v);  chk("R1 int", v, 16'h8080);
    rd(A_STAT, v); chk("R1 stat", v, 16'h0000);
    rd(A_CFG, v);  chk("R1 cfg", v, 16'h40C0);
    rd(A_CMD, v);  chk("R1 cmd", v, 16'h0000);
    chk("R1 rdy", {15'h0, rdy_o}, 16'h1);
    chk("R3 irq after cold reset", {15'h0, irq_o}, 16'h1);
  endtask

  task automatic t_cmd_blocked_at_start;
    wr(A_CMD, 16'h0094);
    chk("R8 no start while pending", {15'h0, cmd_start}, 16'h0);
    rd(A_CMD, v); chk("R8 cmd slot unchanged", v, 16'h0000);
  endtask

  task automatic t_and_clear;
    wr(A_INT, 16'h7FFF);
    rd(A_INT, v); chk("R4 AND clear", v, 16'h0080);
    chk("R3 irq low after pending cleared", {15'h0, irq_o}, 16'h0);
    wr(A_INT, 16'h0000);
    rd(A_INT, v); chk("R4 clear all", v, 16'h0000);
  endtask

  task automatic t_cmd_accept;
    wr(A_CMD, 16'h0094);
    chk("R9 start pulse", {15'h0, cmd_start}, 16'h1);
    chk("R9 cmd_code", cmd_code, 16'h0094);
    @(negedge clk);
    chk("R9 start is one cycle", {15'h0, cmd_start}, 16'h0);
    rd(A_CMD, v); chk("R9 cmd slot", v, 16'h0094);
  endtask

  task automatic t_event_and_block;
    evt(2'd1, 1'b0);
    rd(A_INT, v);  chk("R6 erase event", v, 16'h8020);
    rd(A_STAT, v); chk("R6 no error", v, 16'h0000);
    chk("R3 irq high on pending", {15'h0, irq_o}, 16'h1);
    wr(A_CMD, 16'h0080);
    chk("R8 blocked start", {15'h0, cmd_start}, 16'h0);
    rd(A_CMD, v); chk("R8 cmd kept", v, 16'h0094);
  endtask

  task automatic t_event_errors;
    wr(A_INT, 16'h0000);
    evt(2'd2, 1'b1);
    rd(A_INT, v);  chk("R6 program event", v, 16'h8040);
    rd(A_STAT, v); chk("R7 program error", v, 16'h1400);
    evt(2'd3, 1'b1);
    rd(A_INT, v);  chk("R6 load event", v, 16'h80C0);
    rd(A_STAT, v); chk("R7 load error", v, 16'h3400);
    wr(A_INT, 16'hFFBF);
    rd(A_INT, v);  chk("R4 partial clear", v, 16'h8080);
    rd(A_STAT, v); chk("R5 errors kept while pending", v, 16'h3400);
    wr(A_INT, 16'h7FFF);
    rd(A_STAT, v); chk("R5 errors wiped", v, 16'h0000);
    evt(2'd0, 1'b1);
    rd(A_INT, v);  chk("R6 reset event", v, 16'h8090);
    rd(A_STAT, v); chk("R7 reset kind error", v, 16'h0400);
    wr(A_INT, 16'h0000);
  endtask

  task automatic t_unknown_cmd;
    wr(A_CMD, 16'h0055);
    chk("R10 no start", {15'h0, cmd_start}, 16'h0);
    @(negedge clk);
    chk("R10 still no start", {15'h0, cmd_start}, 16'h0);
    rd(A_INT, v);  chk("R10 pending set", v, 16'h8000);
    rd(A_STAT, v); chk("R10 cmd error", v, 16'h0400);
    rd(A_CMD, v);  chk("R10 stored", v, 16'h0055);
  endtask

  task automatic t_polarity_cfg;
    wr(A_CFG, 16'h0000);
    chk("R11 rdy low", {15'h0, rdy_o}, 16'h0);
    chk("R3 inverted polarity pending", {15'h0, irq_o}, 16'h0);
    wr(A_INT, 16'h0000);
    chk("R3 inverted polarity idle", {15'h0, irq_o}, 16'h1);
    wr(A_CFG, 16'h40DF);
    rd(A_CFG, v); chk("R11 read mask", v, 16'h40C0);
    chk("R11 rdy high", {15'h0, rdy_o}, 16'h1);
    wr(A_CFG, 16'h00FF);
    rd(A_CFG, v); chk("R11 read mask 2", v, 16'h00E0);
    chk("R3 normal polarity idle", {15'h0, irq_o}, 16'h0);
  endtask

  task automatic t_same_cycle;
    evt(2'd1, 1'b1);
    rd(A_STAT, v); chk("R7 erase error", v, 16'h0C00);
    @(negedge clk);
    host_wr_en = 1'b1; host_addr = A_INT; host_wdata = 16'h0000;
    evt_valid = 1'b1; evt_type = 2'd3; evt_err = 1'b0;
    @(negedge clk);
    host_wr_en = 1'b0; evt_valid = 1'b0;
    rd(A_INT, v);  chk("R13 event survives clear", v, 16'h8080);
    rd(A_STAT, v); chk("R13 wipe then event", v, 16'h0000);
  endtask

  task automatic t_read_port;
    wr(A_STAT, 16'hFFFF);
    rd(A_STAT, v); chk("R12 status write ignored", v, 16'h0000);
    rd(A_CFG, v);
    @(negedge clk);
    host_rd_en = 1'b1; host_addr = A_INT;
    #1 chk("R12 old data before edge", host_rdata, 16'h00E0);
    @(negedge clk);
    host_rd_en = 1'b0;
    chk("R12 data one cycle later", host_rdata, 16'h8080);
    @(negedge clk);
    chk("R12 data held", host_rdata, 16'h8080);
  endtask

  task automatic t_warm;
    wr(A_CFG, 16'h0000);
    wr(A_INT, 16'h0000);
    wr(A_CMD, 16'h0023);
    evt(2'd2, 1'b1);
    @(negedge clk);
    warm_rst = 1'b1;
    @(negedge clk);
    warm_rst = 1'b0;
    rd(A_INT, v);  chk("R2 int", v, 16'h8010);
    rd(A_STAT, v); chk("R2 stat", v, 16'h0000);
    rd(A_CFG, v);  chk("R2 cfg", v, 16'h40C0);
    rd(A_CMD, v);  chk("R2 cmd", v, 16'h0000);
    chk("R2 rdy", {15'h0, rdy_o}, 16'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_cold_reset();
    t_cmd_blocked_at_start();
    t_and_clear();
    t_cmd_accept();
    t_event_and_block();
    t_event_errors();
    t_unknown_cmd();
    t_polarity_cfg();
    t_same_cycle();
    t_read_port();
    t_warm();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule